// File: doc/BRIEF.md
# Bus Clock Prescaler Tree

This block derives the per-domain clock-enable strobes of a microcontroller clock tree from one free-running system clock. It has five divider stages. The core bus stage counts system-clock cycles. The two peripheral bus stages, the system-timer stage and the converter stage then count strobes of the stage above them. Every output is therefore a single-cycle enable that lands on a cycle where its parent domain is also enabled. Logic in each domain runs on the system clock and qualifies its registers with the matching enable.

The divisors come from compact encoded select fields, and these do not map uniformly. On the core bus field, any code with its top bit clear bypasses the divider. The divided codes run 2, 4, 8, 16 and then jump to 64 through 512. The peripheral bus fields use the same bypass idea, and the converter stage can divide by six. Each peripheral bus also drives a timer strobe that runs at twice the bus rate whenever that bus is divided.

A stage adopts a new select value only at the end of its current period. Software can therefore rewrite any field at any moment without producing a short or torn period.

Top module: `bus_prescale_tree`

## Requirements
- R1: The core bus strobe `hclk_en` repeats every N system cycles. N is 1 when `ahb_sel[3]` is 0. For `ahb_sel` values 4'b1000, 4'b1001, 4'b1010 and 4'b1011, N is 2, 4, 8 and 16. For 4'b1100, 4'b1101, 4'b1110 and 4'b1111, N is 64, 128, 256 and 512.
- R2: Each peripheral bus strobe (`pclk_lo_en` from `apbl_sel`, `pclk_hi_en` from `apbh_sel`) fires once every M core bus strobes. M is 1 when bit 2 of the select is 0. For select values 3'b100, 3'b101, 3'b110 and 3'b111, M is 2, 4, 8 and 16.
- R3: `adc_en` fires once every K strobes of `pclk_hi_en`, with K = 2, 4, 6, 8 for `adc_sel` = 0, 1, 2, 3. It is only ever high together with `pclk_hi_en`.
- R4: `systick_en` fires once every 8 core bus strobes and only together with `hclk_en`.
- R5: A bus timer strobe (`tim_lo_en`, `tim_hi_en`) equals its bus strobe when that bus divisor is 1. Otherwise it fires at twice the bus rate with even spacing, and it is always high when its bus strobe is.
- R6: Every strobe is one system cycle wide, and a peripheral bus strobe is never high without `hclk_en`.
- R7: A select change is adopted only when the affected stage completes its period. The period in progress keeps the old divisor, and the following period uses the new one.
- R8: While `rst_n` is low and after its release, every counter starts at zero. With all selects zero, `hclk_en`, both bus strobes and both timer strobes are high on every cycle. `adc_en` is high on the 1st, 3rd, 5th ... cycle after release, and `systick_en` is high first on the 7th.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ahb_sel | input | 4 | Core bus divider select |
| apbl_sel | input | 3 | Low-speed peripheral bus divider select |
| apbh_sel | input | 3 | High-speed peripheral bus divider select |
| adc_sel | input | 2 | Converter divider select (counts high-speed bus strobes) |
| hclk_en | output | 1 | Core bus enable strobe |
| pclk_lo_en | output | 1 | Low-speed peripheral bus enable strobe |
| pclk_hi_en | output | 1 | High-speed peripheral bus enable strobe |
| tim_lo_en | output | 1 | Timer strobe of the low-speed bus |
| tim_hi_en | output | 1 | Timer strobe of the high-speed bus |
| systick_en | output | 1 | System timer strobe (core bus / 8) |
| adc_en | output | 1 | Converter enable strobe |

## Verification
The hardest case is a select change that arrives part-way through a long period. It only shows the deferred adoption if the change lands strictly between two strobes of the stage in question. To reach it, the bench waits for an observed strobe and changes the field a fixed number of cycles later. It then measures the two following gaps, which must be the old divisor and then the new one. Periods are measured as gaps between consecutive strobes after a settling time long enough to flush the post-reset transient of the converter stage.

// File: rtl/bus_presc_pkg.sv
package bus_presc_pkg;

  localparam int AHB_CODE_W = 4;
  localparam int APB_CODE_W = 3;
  localparam int ADC_CODE_W = 2;
  localparam int DIV_W      = 10;   // holds divisors up to 512

  // Core bus: top bit clear bypasses; otherwise 2..16 then 64..512.
  function automatic logic [DIV_W-1:0] ahb_divisor(input logic [AHB_CODE_W-1:0] code);
    int sh;
    if (!code[AHB_CODE_W-1]) return DIV_W'(1);
    sh = int'(code[AHB_CODE_W-2:0]) + 1;
    if (code[AHB_CODE_W-2]) sh = sh + 1;   // skip the divide-by-32 step
    return DIV_W'(1) << sh;
  endfunction

  // Peripheral bus: top bit clear bypasses; otherwise 2, 4, 8, 16.
  function automatic logic [DIV_W-1:0] apb_divisor(input logic [APB_CODE_W-1:0] code);
    if (!code[APB_CODE_W-1]) return DIV_W'(1);
    return DIV_W'(1) << (int'(code[APB_CODE_W-2:0]) + 1);
  endfunction

  // Converter: even divisors 2, 4, 6, 8.
  function automatic logic [DIV_W-1:0] adc_divisor(input logic [ADC_CODE_W-1:0] code);
    return DIV_W'((int'(code) + 1) * 2);
  endfunction

endpackage

// File: rtl/presc_decode.sv
module presc_decode
  import bus_presc_pkg::*;
(
  input  logic [AHB_CODE_W-1:0] ahb_sel,
  input  logic [APB_CODE_W-1:0] apbl_sel,
  input  logic [APB_CODE_W-1:0] apbh_sel,
  input  logic [ADC_CODE_W-1:0] adc_sel,
  output logic [DIV_W-1:0]      ahb_div,
  output logic [DIV_W-1:0]      apbl_div,
  output logic [DIV_W-1:0]      apbh_div,
  output logic [DIV_W-1:0]      adc_div
);

  always_comb begin
    ahb_div  = ahb_divisor(ahb_sel);
    apbl_div = apb_divisor(apbl_sel);
    apbh_div = apb_divisor(apbh_sel);
    adc_div  = adc_divisor(adc_sel);
  end

endmodule

// File: rtl/presc_stage.sv
// One cascaded divider stage: counts upstream strobes, emits one strobe
// per period, and adopts a new divisor only on its wrap cycle.
module presc_stage #(
  parameter int DIV_W   = 10,
  parameter int RST_DIV = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_en,
  input  logic [DIV_W-1:0] div_next,
  output logic             strobe
);

  localparam logic [DIV_W-1:0] RST_V = DIV_W'(RST_DIV);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_q;
  logic             wrap;

  assign wrap   = (cnt_q == div_q - 1'b1);
  assign strobe = up_en & wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      div_q <= RST_V;
    end else if (up_en) begin
      if (wrap) begin
        cnt_q <= '0;
        div_q <= div_next;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assert_latch_on_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q != $past(div_q)) |-> $past(strobe));

  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < div_q);

  assert_div_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    div_next != '0);

endmodule

// File: rtl/bus_stage.sv
// Peripheral bus divider with a timer tap that doubles the rate when divided.
module bus_stage #(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_en,
  input  logic [DIV_W-1:0] div_next,
  output logic             strobe,
  output logic             tim_strobe
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] half_m1;
  logic             wrap;
  logic             mid;

  assign wrap       = (cnt_q == div_q - 1'b1);
  assign half_m1    = (div_q >> 1) - 1'b1;
  assign mid        = (div_q != DIV_W'(1)) && (cnt_q == half_m1);
  assign strobe     = up_en & wrap;
  assign tim_strobe = up_en & (wrap | mid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      div_q <= DIV_W'(1);
    end else if (up_en) begin
      if (wrap) begin
        cnt_q <= '0;
        div_q <= div_next;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assert_bus_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q != $past(div_q)) |-> $past(strobe));

  assert_tim_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tim_strobe && !strobe && div_q > DIV_W'(2)) |=> !tim_strobe);

endmodule

// File: rtl/bus_prescale_tree.sv
module bus_prescale_tree
  import bus_presc_pkg::*;
#(
  parameter int TICK_DIV = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [AHB_CODE_W-1:0] ahb_sel,
  input  logic [APB_CODE_W-1:0] apbl_sel,
  input  logic [APB_CODE_W-1:0] apbh_sel,
  input  logic [ADC_CODE_W-1:0] adc_sel,
  output logic                  hclk_en,
  output logic                  pclk_lo_en,
  output logic                  pclk_hi_en,
  output logic                  tim_lo_en,
  output logic                  tim_hi_en,
  output logic                  systick_en,
  output logic                  adc_en
);

  localparam int NBUS = 2;
  localparam logic [DIV_W-1:0] TICK_V = DIV_W'(TICK_DIV);

  logic [DIV_W-1:0] ahb_div, apbl_div, apbh_div, adc_div;
  logic [DIV_W-1:0] bus_div [NBUS];
  logic [NBUS-1:0]  bus_en;
  logic [NBUS-1:0]  tim_en;

  presc_decode u_dec (
    .ahb_sel  (ahb_sel),
    .apbl_sel (apbl_sel),
    .apbh_sel (apbh_sel),
    .adc_sel  (adc_sel),
    .ahb_div  (ahb_div),
    .apbl_div (apbl_div),
    .apbh_div (apbh_div),
    .adc_div  (adc_div)
  );

  // Root stage counts every system clock cycle.
  presc_stage #(.DIV_W(DIV_W), .RST_DIV(1)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_en    (1'b1),
    .div_next (ahb_div),
    .strobe   (hclk_en)
  );

  assign bus_div[0] = apbl_div;
  assign bus_div[1] = apbh_div;

  for (genvar b = 0; b < NBUS; b++) begin : g_bus
    bus_stage #(.DIV_W(DIV_W)) u_bus (
      .clk        (clk),
      .rst_n      (rst_n),
      .up_en      (hclk_en),
      .div_next   (bus_div[b]),
      .strobe     (bus_en[b]),
      .tim_strobe (tim_en[b])
    );
  end

  assign pclk_lo_en = bus_en[0];
  assign pclk_hi_en = bus_en[1];
  assign tim_lo_en  = tim_en[0];
  assign tim_hi_en  = tim_en[1];

  presc_stage #(.DIV_W(DIV_W), .RST_DIV(TICK_DIV)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_en    (hclk_en),
    .div_next (TICK_V),
    .strobe   (systick_en)
  );

  presc_stage #(.DIV_W(DIV_W), .RST_DIV(2)) u_adc (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_en    (pclk_hi_en),
    .div_next (adc_div),
    .strobe   (adc_en)
  );

  assert_lo_nest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pclk_lo_en |-> hclk_en);

  assert_hi_nest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pclk_hi_en |-> hclk_en);

  assert_adc_nest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adc_en |-> pclk_hi_en);

  assert_tick_nest_R4: assert property (@(posedge clk) disable iff (!rst_n)
    systick_en |-> hclk_en);

  assert_tim_cover_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pclk_lo_en |-> tim_lo_en) and (pclk_hi_en |-> tim_hi_en));

endmodule

// File: tb/bus_prescale_tree_test.sv
`timescale 1ns/1ps
module bus_prescale_tree_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] ahb_sel = '0;
  logic [2:0] apbl_sel = '0;
  logic [2:0] apbh_sel = '0;
  logic [1:0] adc_sel = '0;
  logic hclk_en, pclk_lo_en, pclk_hi_en, tim_lo_en, tim_hi_en, systick_en, adc_en;

  always #2.5 clk = ~clk;

  bus_prescale_tree uut (
    .clk(clk), .rst_n(rst_n), .ahb_sel(ahb_sel), .apbl_sel(apbl_sel),
    .apbh_sel(apbh_sel), .adc_sel(adc_sel), .hclk_en(hclk_en),
    .pclk_lo_en(pclk_lo_en), .pclk_hi_en(pclk_hi_en), .tim_lo_en(tim_lo_en),
    .tim_hi_en(tim_hi_en), .systick_en(systick_en), .adc_en(adc_en)
  );

  int checks = 0;
  int fails  = 0;
  int gap [7];
  int last [7];
  int nest_err;

  // {ahb[3:0], apbl[2:0], apbh[2:0], adc[1:0]}
  localparam logic [11:0] VEC [8] = '{
    {4'b0000, 3'b000, 3'b000, 2'b00},
    {4'b1000, 3'b100, 3'b101, 2'b01},
    {4'b1011, 3'b111, 3'b110, 2'b10},
    {4'b1100, 3'b011, 3'b100, 2'b11},
    {4'b1111, 3'b101, 3'b000, 2'b00},
    {4'b0110, 3'b110, 3'b111, 2'b11},
    {4'b1001, 3'b010, 3'b011, 2'b10},
    {4'b1101, 3'b100, 3'b111, 2'b01}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [6:0] taps();
    return {adc_en, systick_en, tim_hi_en, tim_lo_en, pclk_hi_en, pclk_lo_en, hclk_en};
  endfunction

  function automatic int exp_core(input logic [3:0] c);
    if (!c[3]) return 1;
    case (c[2:0])
      3'd0: return 2;   3'd1: return 4;   3'd2: return 8;   3'd3: return 16;
      3'd4: return 64;  3'd5: return 128; 3'd6: return 256; default: return 512;
    endcase
  endfunction

  function automatic int exp_bus(input logic [2:0] c);
    if (!c[2]) return 1;
    case (c[1:0])
      2'd0: return 2; 2'd1: return 4; 2'd2: return 8; default: return 16;
    endcase
  endfunction

  function automatic int exp_adc(input logic [1:0] c);
    case (c)
      2'd0: return 2; 2'd1: return 4; 2'd2: return 6; default: return 8;
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_window(input int settle, input int window);
    logic [6:0] s;
    repeat (settle) @(negedge clk);
    for (int i = 0; i < 7; i++) begin gap[i] = 0; last[i] = -1; end
    nest_err = 0;
    for (int c = 0; c < window; c++) begin
      @(negedge clk);
      s = taps();
      if ((s[1] || s[2]) && !s[0]) nest_err++;
      for (int i = 0; i < 7; i++) begin
        if (s[i]) begin
          if (last[i] >= 0 && gap[i] == 0) gap[i] = c - last[i];
          last[i] = c;
        end
      end
    end
  endtask

  // Returns the gaps between the next three strobes of one output, after
  // changing a select field `delay` cycles past an observed strobe.
  task automatic change_mid(input int which, input int delay, input logic [3:0] new_code,
                            output int g1, output int g2);
    int c, t1, t2;
    logic [6:0] s;
    do begin @(negedge clk); s = taps(); end while (!s[which]);
    c = 0;
    repeat (delay) @(negedge clk);
    c = delay;
    if (which == 0) ahb_sel = new_code; else apbl_sel = new_code[2:0];
    t1 = -1; t2 = -1;
    while (t2 < 0 && c < 4000) begin
      @(negedge clk); c++;
      s = taps();
      if (s[which]) begin
        if (t1 < 0) t1 = c; else t2 = c;
      end
    end
    g1 = t1;
    g2 = t2 - t1;
  endtask

  initial begin
    #950000;
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [6:0] s;
    int ah, lo, hi, ad, maxp, g1, g2;
    int p [7];

    // R8: reset state with all selects zero
    do_reset();
    for (int n = 1; n <= 8; n++) begin
      @(negedge clk);
      s = taps();
      check("R8 bus/timer strobes every cycle", int'(s[4:0]), 31);
      check("R8 systick first on 7th cycle", int'(s[5]), (n == 7) ? 1 : 0);
      check("R8 adc on odd cycles", int'(s[6]), (n % 2 == 1) ? 1 : 0);
    end

    // Table-driven period checks
    for (int v = 0; v < 8; v++) begin
      {ahb_sel, apbl_sel, apbh_sel, adc_sel} = VEC[v];
      ah = exp_core(ahb_sel); lo = exp_bus(apbl_sel);
      hi = exp_bus(apbh_sel); ad = exp_adc(adc_sel);
      p[0] = ah; p[1] = ah * lo; p[2] = ah * hi;
      p[3] = (lo == 1) ? ah : ah * lo / 2;
      p[4] = (hi == 1) ? ah : ah * hi / 2;
      p[5] = 8 * ah; p[6] = ah * hi * ad;
      maxp = 0;
      for (int i = 0; i < 7; i++) if (p[i] > maxp) maxp = p[i];
      do_reset();
      run_window(2 * maxp + 16, 2 * maxp + 8);
      check($sformatf("R1 core period vec%0d", v), gap[0], p[0]);
      check($sformatf("R2 low bus period vec%0d", v), gap[1], p[1]);
      check($sformatf("R2 high bus period vec%0d", v), gap[2], p[2]);
      check($sformatf("R5 low timer period vec%0d", v), gap[3], p[3]);
      check($sformatf("R5 high timer period vec%0d", v), gap[4], p[4]);
      check($sformatf("R4 systick period vec%0d", v), gap[5], p[5]);
      check($sformatf("R3 adc period vec%0d", v), gap[6], p[6]);
      check($sformatf("R6 bus strobe without core vec%0d", v), nest_err, 0);
    end

    // R7: core divider change mid-period (div 8 -> div 2)
    ahb_sel = 4'b1010; apbl_sel = '0; apbh_sel = '0; adc_sel = '0;
    do_reset();
    repeat (20) @(negedge clk);
    change_mid(0, 2, 4'b1000, g1, g2);
    check("R7 core old period completes", g1, 8);
    check("R7 core new period adopted", g2, 2);

    // R7: low bus divider change mid-period (div 16 -> div 2), core undivided
    ahb_sel = 4'b0000; apbl_sel = 3'b111;
    do_reset();
    repeat (40) @(negedge clk);
    change_mid(1, 5, 4'b0100, g1, g2);
    check("R7 bus old period completes", g1, 16);
    check("R7 bus new period adopted", g2, 2);

    // R6: single-cycle strobe with core divide-by-2
    ahb_sel = 4'b1000; apbl_sel = '0;
    do_reset();
    repeat (10) @(negedge clk);
    do @(negedge clk); while (!hclk_en);
    @(negedge clk);
    check("R6 core strobe one cycle wide", int'(hclk_en), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule